// File: doc/BRIEF.md
# Reference Prescaler and Clock Monitor Tile Wrapper

This block sits between a small test tile's pins and a phase-locked loop core. On the system clock it produces the loop's reference clock with a 4-bit programmable down counter. When the prescaler setting is zero, the counter is bypassed and the system clock itself becomes the reference. The low nibble of the input bus goes unchanged to the loop's feedback count, and the system reset goes straight to the loop's reset input.

On the loop's side, the block packs its observations onto the output bus. These are the raw loop clock, the loop's active-low reset-out, and four divided copies of the loop clock (divide by 2, 4, 8 and 16). The divided copies come from a binary counter clocked by the loop clock. That counter stays cleared while the reset-out is low. Scope probes on the pins then show the loop frequency even when the raw clock is too fast to leave the chip.

The loop core itself is outside this block. The bench supplies its clock and reset-out as stimulus.

Top module: `tile_clkmon`

## Requirements
- R1: `pll_count` equals `cfg_in[3:0]` at all times, and `pll_rst_n` equals `sys_rst_n` at all times.
- R2: With prescaler setting N = `cfg_in[7:4]` in 1..15, `pll_refclk` toggles once every N+1 rising edges of `sys_clk`. This gives a period of 2·(N+1) system cycles.
- R3: With `cfg_in[7:4]` = 0, `pll_refclk` equals `sys_clk`.
- R4: A new prescaler setting is taken only when the counter reloads. An interval already in progress ends after the old setting's count, and the following interval uses the new one.
- R5: `tile_out[0]` equals `pll_clk`, `tile_out[1]` equals `pll_lock_n`, and `tile_out[7:6]` is always 0.
- R6: While `pll_lock_n` is low, `tile_out[5:2]` is 0. Clearing is asynchronous to the loop clock.
- R7: After `pll_lock_n` rises, `tile_out[5:2]` holds 0 through two rising edges of `pll_clk`. After the k-th rising edge (k ≥ 2) it reads (k−2) mod 16. So bit 2 is the loop clock divided by 2, up to bit 5 for divide by 16.
- R8: While `sys_rst_n` is low, the prescaler output is low. After release, with a nonzero setting, `pll_refclk` first goes high on the third rising edge of `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous assert |
| cfg_in | input | 8 | [3:0] loop feedback count, [7:4] reference prescaler setting |
| tile_out | output | 8 | [0] loop clock, [1] loop reset-out, [5:2] divided loop clock, [7:6] zero |
| pll_refclk | output | 1 | Reference clock to the loop core |
| pll_count | output | 4 | Feedback count to the loop core |
| pll_rst_n | output | 1 | Reset to the loop core |
| pll_clk | input | 1 | Output clock of the loop core |
| pll_lock_n | input | 1 | Active-low reset-out of the loop core |

## Verification
The prescaler is swept over all fifteen nonzero settings, and the interval between reference toggles is measured in system cycles. Each setting has its own expected interval, so an off-by-one in the reload or in the terminal detect shows up as a wrong count. A mid-interval change from 7 to 2 separates loading at the reload from loading immediately. The zero setting is probed in both clock phases to confirm the bypass. On the loop side, the divider is followed edge by edge for forty cycles after lock, which covers the two-edge release delay and a wrap. An asynchronous drop of the lock mid-count confirms the clear.

// File: rtl/tile_clkmon_pkg.sv
package tile_clkmon_pkg;
  localparam int unsigned CNT_W_DEF  = 4;
  localparam int unsigned PRE_W_DEF  = 4;
  localparam int unsigned DIV_W_DEF  = 4;
  localparam int unsigned SYNC_N_DEF = 2;
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] div_set,
  output logic             ref_out
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;
  logic             at_term;
  logic             bypass;

  assign at_term = (cnt_q == '0);
  assign bypass  = (div_set == '0);

  always_comb begin
    cnt_d = cnt_q;
    ref_d = ref_q;
    if (at_term) begin
      cnt_d = div_set;
      ref_d = ~ref_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign ref_out = bypass ? clk : ref_q;
endmodule

// File: rtl/clk_div_chain.sv
module clk_div_chain #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  output logic [DIV_W-1:0] div_out
);
  logic             run;
  logic             cnt_en;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  clkmon_rst_sync #(.STAGES(SYNC_N)) u_run_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (run)
  );

  assign cnt_en = run;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DIV_W; gi++) begin : g_tap
      assign div_out[gi] = cnt_q[gi];
    end
  endgenerate
endmodule

// File: rtl/tile_clkmon.sv
module tile_clkmon
  import tile_clkmon_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned PRE_W  = PRE_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF,
  localparam int unsigned IO_W  = CNT_W + PRE_W
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic [IO_W-1:0]  cfg_in,
  output logic [IO_W-1:0]  tile_out,
  output logic             pll_refclk,
  output logic [CNT_W-1:0] pll_count,
  output logic             pll_rst_n,
  input  logic             pll_clk,
  input  logic             pll_lock_n
);
  localparam int unsigned DIV_LO = 2;
  localparam int unsigned DIV_HI = DIV_LO + DIV_W - 1;

  logic             sys_srst_n;
  logic [DIV_W-1:0] div_bits;

  clkmon_rst_sync #(.STAGES(SYNC_N)) u_sys_sync (
    .clk    (sys_clk),
    .arst_n (sys_rst_n),
    .rst_n  (sys_srst_n)
  );

  ref_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (sys_clk),
    .rst_n   (sys_srst_n),
    .div_set (cfg_in[IO_W-1:CNT_W]),
    .ref_out (pll_refclk)
  );

  clk_div_chain #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_div (
    .clk     (pll_clk),
    .arst_n  (pll_lock_n),
    .div_out (div_bits)
  );

  assign pll_count = cfg_in[CNT_W-1:0];
  assign pll_rst_n = sys_rst_n;

  always_comb begin
    tile_out                = '0;
    tile_out[0]             = pll_clk;
    tile_out[1]             = pll_lock_n;
    tile_out[DIV_HI:DIV_LO] = div_bits;
  end
endmodule

// File: rtl/tile_clkmon_chk.sv
module tile_clkmon_chk (
  input logic       sys_clk,
  input logic       sys_rst_n,
  input logic [7:0] cfg_in,
  input logic [7:0] tile_out,
  input logic       pll_refclk,
  input logic       pll_clk,
  input logic       pll_lock_n
);
  // R5
  hi_bits_zero_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    tile_out[7:6] == 2'b00);

  // R6
  div_clear_chk: assert property (@(posedge pll_clk) disable iff (!sys_rst_n)
    !pll_lock_n |-> (tile_out[5:2] == 4'd0));

  // R7
  div_step_chk: assert property (@(posedge pll_clk) disable iff (!pll_lock_n)
    (tile_out[5:2] != $past(tile_out[5:2])) |->
      (tile_out[5:2] == ($past(tile_out[5:2]) + 4'd1)));

  // R2
  ref_min_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (cfg_in[7:4] != 4'd0 && $past(cfg_in[7:4]) != 4'd0 && $past(cfg_in[7:4], 2) != 4'd0
     && $past(pll_refclk) != $past(pll_refclk, 2))
    |-> (pll_refclk == $past(pll_refclk)));
endmodule

bind tile_clkmon tile_clkmon_chk u_chk (
  .sys_clk    (sys_clk),
  .sys_rst_n  (sys_rst_n),
  .cfg_in     (cfg_in),
  .tile_out   (tile_out),
  .pll_refclk (pll_refclk),
  .pll_clk    (pll_clk),
  .pll_lock_n (pll_lock_n)
);

// File: tb/tile_clkmon_bench.sv
module tile_clkmon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_HALF   = 3;
  localparam int WATCHDOG   = 200000;

  logic       sys_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic       sys_rst_n;
  logic       pll_lock_n;
  logic [7:0] cfg_in;
  logic [7:0] tile_out;
  logic       pll_refclk;
  logic [3:0] pll_count;
  logic       pll_rst_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #(PLL_HALF) pll_clk = ~pll_clk;

  tile_clkmon u_tile_clkmon (
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .cfg_in     (cfg_in),
    .tile_out   (tile_out),
    .pll_refclk (pll_refclk),
    .pll_count  (pll_count),
    .pll_rst_n  (pll_rst_n),
    .pll_clk    (pll_clk),
    .pll_lock_n (pll_lock_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    logic prev;
    prev = pll_refclk;
    n = 0;
    do begin
      @(negedge sys_clk);
      n++;
    end while (pll_refclk == prev);
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int exp_v;
    sys_rst_n  = 1'b1;
    pll_lock_n = 1'b1;
    cfg_in     = 8'h50;
    #1;
    sys_rst_n  = 1'b0;
    pll_lock_n = 1'b0;

    // reset state: R8, R1, R5, R6
    repeat (5) begin
      @(negedge sys_clk);
      #1;
      chk(pll_refclk == 1'b0, "R8 ref low in reset", pll_refclk, 0);
      chk(pll_rst_n == 1'b0, "R1 reset passthrough", pll_rst_n, 0);
      chk(tile_out[7:6] == 2'b00, "R5 upper bits", tile_out[7:6], 0);
      chk(tile_out[5:2] == 4'd0, "R6 div clear in reset", tile_out[5:2], 0);
    end

    // R8: first rise on third rising edge after release
    @(negedge sys_clk);
    sys_rst_n = 1'b1;
    #1;
    chk(pll_rst_n == 1'b1, "R1 reset passthrough", pll_rst_n, 1);
    n = 0;
    do begin
      @(negedge sys_clk);
      n++;
    end while (pll_refclk == 1'b0 && n < 20);
    chk(n == 3, "R8 first reference rise", n, 3);

    // R2: sweep all nonzero settings
    for (int s = 1; s < 16; s++) begin
      cfg_in[7:4] = s[3:0];
      measure(n);
      measure(n);
      chk(n == s + 1, "R2 toggle interval", n, s + 1);
      measure(n);
      chk(n == s + 1, "R2 toggle interval", n, s + 1);
    end

    // R4: change mid interval
    cfg_in[7:4] = 4'd7;
    measure(n);
    measure(n);
    repeat (2) @(negedge sys_clk);
    cfg_in[7:4] = 4'd2;
    n = 2;
    begin
      logic prev;
      prev = pll_refclk;
      do begin
        @(negedge sys_clk);
        n++;
      end while (pll_refclk == prev);
    end
    chk(n == 8, "R4 old setting finishes", n, 8);
    measure(n);
    chk(n == 3, "R4 new setting at reload", n, 3);

    // R3: bypass
    @(negedge sys_clk);
    cfg_in[7:4] = 4'd0;
    repeat (8) begin
      @(posedge sys_clk);
      #1;
      chk(pll_refclk == 1'b1, "R3 bypass high phase", pll_refclk, 1);
      @(negedge sys_clk);
      #1;
      chk(pll_refclk == 1'b0, "R3 bypass low phase", pll_refclk, 0);
    end

    // R1: count passthrough
    for (int c = 0; c < 16; c++) begin
      cfg_in[3:0] = c[3:0];
      #1;
      chk(pll_count == c[3:0], "R1 count passthrough", pll_count, c);
    end

    // R6: held clear while lock low with loop clock running
    repeat (6) begin
      @(negedge pll_clk);
      #1;
      chk(tile_out[5:2] == 4'd0, "R6 div clear while lock low", tile_out[5:2], 0);
      chk(tile_out[1] == 1'b0, "R5 lock bit", tile_out[1], 0);
    end

    // R7 / R5: release and follow
    @(negedge pll_clk);
    pll_lock_n = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge pll_clk);
      #1;
      chk(tile_out[0] == 1'b1, "R5 raw clock high", tile_out[0], 1);
      @(negedge pll_clk);
      #1;
      exp_v = (k <= 2) ? 0 : ((k - 2) % 16);
      chk(tile_out[5:2] == exp_v[3:0], "R7 divider count", tile_out[5:2], exp_v);
      chk(tile_out[0] == 1'b0, "R5 raw clock low", tile_out[0], 0);
      chk(tile_out[1] == 1'b1, "R5 lock bit", tile_out[1], 1);
      chk(tile_out[7:6] == 2'b00, "R5 upper bits", tile_out[7:6], 0);
    end

    // R6: asynchronous clear mid count
    @(posedge pll_clk);
    #1;
    pll_lock_n = 1'b0;
    #1;
    chk(tile_out[5:2] == 4'd0, "R6 async clear", tile_out[5:2], 0);
    chk(tile_out[1] == 1'b0, "R5 lock bit", tile_out[1], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule